// File: doc/BRIEF.md
# Store Buffer with Line-Overlap Commit Gating

This block holds stores that have already retired from the pipeline. Each store is kept as an address and data pair until the L1 data cache accepts it. The cache accepting a store is the moment that store becomes visible to other cores. Entries leave in the order they arrived, and at most one entry leaves per cycle. An entry leaves only through the commit handshake with the cache, so a pipeline flush or rollback cannot remove a retired store.

Before the oldest entry is offered to the cache, its cache-line address is compared with every pending entry of the outstanding-load buffer. If no pending load targets the same line, the store is offered at once, even when older loads are still waiting for their data. A load followed by a store to a different line can therefore become visible out of order. If some pending load targets the same line, the store waits until that load's fill completes, which is seen as its pending flag dropping.

When all entries are occupied, the block deasserts its ready output and the store execution stage stalls.

Top module: `scb_commit`

## Requirements
- R1: After reset the buffer is empty, `st_ready` is 1 and `cm_valid` is 0.
- R2: A store is accepted on a rising edge where `st_valid` and `st_ready` are both 1. It can first be offered to the cache in the following cycle, never in the cycle it is accepted.
- R3: Stores are offered on `cm_addr`/`cm_data` in acceptance order. One store leaves on each edge where `cm_valid` and `cm_ready` are both 1.
- R4: The oldest store is offered (`cm_valid`=1) whenever no pending load shares its cache line, regardless of how many loads to other lines are pending.
- R5: The oldest store is not offered while any load with `ld_valid[i]`=1 has `ld_line[i*LW +: LW]` equal to the store's line address, `st_addr[AW-1:OFFS]` with OFFS = log2(LINE_BYTES). The offset bits below OFFS play no part in the comparison.
- R6: When every matching load's `ld_valid` bit drops (fill complete), the held store is offered in that same cycle.
- R7: While `cm_valid` is 1 and `cm_ready` is 0, the offered address and data stay unchanged on the next cycle, and no entry is lost.
- R8: With DEPTH entries occupied, `st_ready` is 0 and a store offered then is not accepted.
- R9: Entries are removed only by the commit handshake. Holding `cm_ready` low keeps every accepted store in the buffer for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store execution stage offers a store |
| st_addr | input | AW | Byte address of the offered store |
| st_data | input | DW | Data of the offered store |
| st_ready | output | 1 | Buffer has room; low stalls the store stage |
| ld_valid | input | NLD | Pending flag per outstanding-load entry |
| ld_line | input | NLD*LW | Line address per load entry, entry i at bits i*LW |
| cm_valid | output | 1 | Oldest store offered to the L1 data cache |
| cm_addr | output | AW | Address of the offered store |
| cm_data | output | DW | Data of the offered store |
| cm_ready | input | 1 | Cache accepts the offered store this cycle |

## Verification
The bench sets up a pending load that shares a line with the head store but differs in its offset bits. A design that compared full addresses would commit that store early, and one that ignored the loads would commit it at once. It also keeps loads pending to other lines while the head waits, so an over-cautious design that held every store behind any pending load shows up as a missing `cm_valid`. Filling the buffer and then offering one more store catches an overwrite or a lost entry. Long stretches with `cm_ready` low, mixed with random load traffic, catch a head that moves or drops entries while it is stalled.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int SCB_AW         = 32;
    localparam int SCB_DW         = 32;
    localparam int SCB_DEPTH      = 4;
    localparam int SCB_NLD        = 4;
    localparam int SCB_LINE_BYTES = 64;

    typedef enum logic [1:0] {
        HEAD_EMPTY = 2'd0,
        HEAD_HELD  = 2'd1,
        HEAD_OFFER = 2'd2
    } head_state_e;
endpackage

// File: rtl/scb_fifo.sv
module scb_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t           st_d, st_q;
    logic [W-1:0]   mem_d [DEPTH];
    logic [W-1:0]   mem_q [DEPTH];

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
        mem_q <= mem_d;
    end

    assign head_data = mem_q[st_q.rp];
    assign full      = (st_q.cnt == FULLC);
    assign empty     = (st_q.cnt == '0);
endmodule

// File: rtl/scb_overlap.sv
module scb_overlap #(
    parameter int NLD = 4,
    parameter int LW  = 26
) (
    input  logic [LW-1:0]     probe_line,
    input  logic [NLD-1:0]    ld_valid,
    input  logic [NLD*LW-1:0] ld_line,
    output logic              overlap
);
    logic [NLD-1:0] hit;

    for (genvar i = 0; i < NLD; i++) begin : g_probe
        assign hit[i] = ld_valid[i] && (ld_line[i*LW +: LW] == probe_line);
    end

    assign overlap = |hit;
endmodule

// File: rtl/scb_commit.sv
module scb_commit
    import scb_pkg::*;
#(
    parameter int AW         = SCB_AW,
    parameter int DW         = SCB_DW,
    parameter int DEPTH      = SCB_DEPTH,
    parameter int NLD        = SCB_NLD,
    parameter int LINE_BYTES = SCB_LINE_BYTES,
    localparam int OFFS      = $clog2(LINE_BYTES),
    localparam int LW        = AW - OFFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [AW-1:0]     st_addr,
    input  logic [DW-1:0]     st_data,
    output logic              st_ready,
    input  logic [NLD-1:0]    ld_valid,
    input  logic [NLD*LW-1:0] ld_line,
    output logic              cm_valid,
    output logic [AW-1:0]     cm_addr,
    output logic [DW-1:0]     cm_data,
    input  logic              cm_ready
);
    localparam int EW = AW + DW;

    logic          full, empty, overlap, push, pop;
    logic [EW-1:0] head;
    head_state_e   head_st;

    assign push = st_valid && !full;
    assign pop  = cm_valid && cm_ready;

    scb_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({st_addr, st_data}),
        .pop       (pop),
        .head_data (head),
        .full      (full),
        .empty     (empty)
    );

    assign cm_addr = head[EW-1:DW];
    assign cm_data = head[DW-1:0];

    scb_overlap #(.NLD(NLD), .LW(LW)) u_overlap (
        .probe_line (cm_addr[AW-1:OFFS]),
        .ld_valid   (ld_valid),
        .ld_line    (ld_line),
        .overlap    (overlap)
    );

    always_comb begin
        if (empty)        head_st = HEAD_EMPTY;
        else if (overlap) head_st = HEAD_HELD;
        else              head_st = HEAD_OFFER;
    end

    assign cm_valid = (head_st == HEAD_OFFER);
    assign st_ready = !full;
endmodule

// File: rtl/scb_commit_chk.sv
module scb_commit_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int NLD   = 4,
    parameter int LW    = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [NLD-1:0]    ld_valid,
    input logic [NLD*LW-1:0] ld_line,
    input logic              cm_valid,
    input logic [AW-1:0]     cm_addr,
    input logic [DW-1:0]     cm_data,
    input logic              cm_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ_q;
    logic          hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            case ({st_valid && st_ready, cm_valid && cm_ready})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NLD; i++) begin
            if (ld_valid[i] && ld_line[i*LW +: LW] == cm_addr[AW-1:AW-LW]) hit = 1'b1;
        end
    end

    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !cm_valid);

    p_clear_offers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q != '0 && !hit) |-> cm_valid);

    p_same_line_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> !hit);

    p_stall_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> ($stable(cm_addr) && $stable(cm_data)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CW'(DEPTH)) |-> !st_ready);

    p_room_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q < CW'(DEPTH)) |-> st_ready);
endmodule

bind scb_commit scb_commit_chk #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .NLD(NLD), .LW(LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .ld_valid (ld_valid),
    .ld_line  (ld_line),
    .cm_valid (cm_valid),
    .cm_addr  (cm_addr),
    .cm_data  (cm_data),
    .cm_ready (cm_ready)
);

// File: tb/tb_scb_commit.sv
module tb_scb_commit;
    localparam int AW = 32, DW = 32, DEPTH = 4, NLD = 4, LW = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [AW-1:0]     st_addr = '0;
    logic [DW-1:0]     st_data = '0;
    logic              st_ready;
    logic [NLD-1:0]    ld_valid = '0;
    logic [NLD*LW-1:0] ld_line = '0;
    logic              cm_valid;
    logic [AW-1:0]     cm_addr;
    logic [DW-1:0]     cm_data;
    logic              cm_ready = 1'b0;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];

    always #4 clk = ~clk;

    scb_commit dut (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_overlap(input logic [AW-1:0] a);
        bit h = 1'b0;
        for (int i = 0; i < NLD; i++)
            if (ld_valid[i] && ld_line[i*LW +: LW] == a[AW-1:6]) h = 1'b1;
        return h;
    endfunction

    function automatic bit exp_valid();
        return (qa.size() > 0) && !exp_overlap(qa[0]);
    endfunction

    // called just after a negedge with inputs already set
    task automatic cycle(input string tag);
        bit ev, er;
        #1;
        ev = exp_valid();
        er = (qa.size() < DEPTH);
        check(tag, "cm_valid", cm_valid, ev);
        check(tag, "st_ready", st_ready, er);
        if (ev) begin
            check("R3", "cm_addr", cm_addr, qa[0]);
            check("R3", "cm_data", cm_data, qd[0]);
        end
        @(posedge clk);
        if (ev && cm_ready) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        if (st_valid && er) begin
            qa.push_back(st_addr);
            qd.push_back(st_data);
        end
        @(negedge clk);
    endtask

    task automatic set_ld(input int i, input bit v, input logic [LW-1:0] ln);
        ld_valid[i] = v;
        ld_line[i*LW +: LW] = ln;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "st_ready in reset", st_ready, 1'b1);
        rst_n = 1'b1;
        #1;
        check("R1", "cm_valid after reset", cm_valid, 1'b0);
        check("R1", "st_ready after reset", st_ready, 1'b1);
        @(negedge clk);

        // R2: accepted store not offered in the accepting cycle
        cm_ready = 1'b0;
        st_valid = 1'b1; st_addr = 32'h0000_1024; st_data = 32'hA0A0_0001;
        cycle("R2");
        st_valid = 1'b0;
        cycle("R2");
        check("R2", "offered next cycle", cm_valid, 1'b1);

        // R7/R9: stall with cm_ready low
        repeat (4) cycle("R7");
        check("R9", "entry kept", cm_addr, 32'h0000_1024);

        // R8: fill to DEPTH then one more
        for (int k = 0; k < 3; k++) begin
            st_valid = 1'b1; st_addr = 32'h0000_2000 + 32'(k * 64); st_data = 32'hB000_0000 + 32'(k);
            cycle("R8");
        end
        st_addr = 32'h0000_9000; st_data = 32'hDEAD_BEEF;
        #1;
        check("R8", "st_ready when full", st_ready, 1'b0);
        cycle("R8");
        st_valid = 1'b0;

        // R5: pending load on same line, other offset (head 0x1024 -> line 0x40)
        set_ld(2, 1'b1, 26'h40);
        set_ld(0, 1'b1, 26'h77);
        cm_ready = 1'b1;
        #1;
        check("R5", "held on same line", cm_valid, 1'b0);
        repeat (3) cycle("R5");

        // R6: fill completes
        set_ld(2, 1'b0, 26'h40);
        #1;
        check("R6", "released on fill", cm_valid, 1'b1);
        cycle("R6");

        // R4: other-line loads pending, head 0x2000 commits
        set_ld(1, 1'b1, 26'h81);
        #1;
        check("R4", "commit past other-line load", cm_valid, 1'b1);
        check("R4", "head addr", cm_addr, 32'h0000_2000);
        cycle("R4");
        ld_valid = '0;
        repeat (3) cycle("R3");
        check("R8", "overflow store dropped", qa.size(), 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            st_valid = ($urandom_range(0, 9) < 6);
            st_addr  = {6'd0, 20'h40 + 20'($urandom_range(0, 7)), 6'($urandom)};
            st_data  = $urandom;
            cm_ready = ($urandom_range(0, 9) < ((n / 500) % 2 == 1 ? 2 : 7));
            for (int i = 0; i < NLD; i++)
                set_ld(i, ($urandom_range(0, 9) < 2), 26'h40 + 26'($urandom_range(0, 7)));
            cycle("R5");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule